// File: doc/BRIEF.md
# Store-Driven Instruction Line Coherence Detector

This block sits next to a processor front end and keeps the instruction side coherent with the core's own data stores. Each instruction line the front end fetches is recorded in a small tracking table. Each committed data store is reduced to its 32-byte line tag and compared against that table. A store that hits a tracked line while the core runs in legacy mode, with both data and instruction translation enabled, is queued as a pending hit. Stores made in native mode, and stores made while either translation is off, never match.

Queued hits are not acted on at once. New instruction bytes only have to be visible after a later branch retires, so the detector waits for the branch-retire strobe. It then drains the queue as a series of line-invalidate requests, each held until the cache acknowledges it. After the last one it pulses a refetch request. If more distinct lines are hit than the queue can hold, it issues one whole instruction-cache flush instead. A mode-switch strobe, which marks the move from legacy to native execution, starts the same drain and holds a stall output high until the drain is complete.

The control is a three-state machine. IDLE leaves on a branch-retire or mode-switch strobe when something is pending, which is the transition *start*. DRAIN issues invalidates or the flush and leaves when the queue is empty and the overflow mark is clear, which is *drained*. DONE lasts one cycle, raises refetch, and returns to IDLE, which is *resume*. A mode-switch strobe that arrives during DRAIN sets the stall cause. That transition is *escalate*, and the state stays DRAIN.

Top module: `smc_detector`

## Requirements
- R1: While reset is asserted and after its release, with no other activity, inv_req, flush_req, refetch and stall are all 0 and nothing is pending.
- R2: A store whose line tag (address bits 31:5) equals a tracked fetched line, made with mode_legacy=1, xlat_data_en=1 and xlat_inst_en=1, is queued. The branch-retire strobe that follows raises inv_req with inv_line equal to that tag in the next cycle.
- R3: A queued hit raises no inv_req until br_retire or mode_switch is sampled high at a clock edge after the one that accepted the store.
- R4: A store made with mode_legacy=0 is ignored: a later branch-retire strobe raises neither inv_req nor flush_req.
- R5: A store made with xlat_data_en=0 or xlat_inst_en=0 is ignored in the same way.
- R6: Only bits 31:5 are compared. A store at any byte offset inside a tracked line hits, and a store to a line that is not tracked does not.
- R7: Up to 4 distinct pending lines are invalidated one at a time, in store order. Each request stays high with a stable inv_line until inv_ack is sampled. A repeat store to a line that is already pending adds no entry.
- R8: A fifth distinct pending line sets overflow. The drain then raises flush_req, never inv_req, and holds it until flush_ack. The flush clears every pending entry and every tracked line.
- R9: Once the last invalidate or the flush is acknowledged, the block spends one cycle with no request, then raises refetch for exactly one cycle, then returns to idle.
- R10: A mode_switch strobe with hits pending raises stall in the next cycle and holds it through the refetch cycle. Stall is 0 in the cycle after. A mode_switch strobe with nothing pending leaves stall at 0.
- R11: An acknowledged invalidate removes that line from the tracking table, so a later store to that line no longer hits.
- R12: The tracking table holds 8 lines and replaces the oldest entry. A ninth distinct fetched line evicts the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_legacy | input | 1 | 1 = legacy execution mode, 0 = native |
| xlat_data_en | input | 1 | Data address translation enabled |
| xlat_inst_en | input | 1 | Instruction address translation enabled |
| st_valid | input | 1 | Committed store strobe |
| st_addr | input | 32 | Physical store address |
| fl_valid | input | 1 | Fetched-line record strobe |
| fl_addr | input | 32 | Physical address of the fetched line |
| br_retire | input | 1 | Branch retired strobe |
| mode_switch | input | 1 | Legacy-to-native transition strobe |
| inv_ack | input | 1 | Instruction cache accepted inv_req |
| flush_ack | input | 1 | Instruction cache accepted flush_req |
| inv_req | output | 1 | Invalidate one instruction line |
| inv_line | output | 27 | Line tag to invalidate |
| flush_req | output | 1 | Flush the whole instruction cache |
| refetch | output | 1 | One-cycle request to refetch |
| stall | output | 1 | Hold native fetch until coherence completes |

## Verification
Every combination of mode and the two translation enables is tried against the same tracked line. This shows that only the fully qualified combination queues a hit. The number of distinct hit lines is swept from one to five, each sweep with a repeated store mixed in. Counts of one to four must give ordered invalidates, and five must switch to a single flush, so the sweep locates the overflow boundary and exercises de-duplication. Further patterns cover an in-line byte offset against a neighbouring untracked line, eviction from the tracking table, a store to a line that was just invalidated, and a mode switch with and without pending hits. Together these separate the queue, the tracking table and the stall path.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DONE  = 2'd2
    } smc_state_e;
endpackage

// File: rtl/smc_line_tracker.sv
// Table of recently fetched instruction line tags with oldest-first replacement.
module smc_line_tracker #(
    parameter int TAG_W   = 27,
    parameter int TRACK_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic [TAG_W-1:0] rec_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  logic             drop_en,
    input  logic [TAG_W-1:0] drop_tag,
    input  logic             drop_all,
    output logic             probe_hit
);
    localparam int PTR_W = (TRACK_N > 1) ? $clog2(TRACK_N) : 1;

    logic [TAG_W-1:0] tag_q [TRACK_N];
    logic [TRACK_N-1:0] vld_q;
    logic [TRACK_N-1:0] probe_m;
    logic [TRACK_N-1:0] rec_m;
    logic [PTR_W-1:0]   ptr_q;
    logic               rec_dup;

    for (genvar i = 0; i < TRACK_N; i++) begin : g_cmp
        assign probe_m[i] = vld_q[i] && (tag_q[i] == probe_tag);
        assign rec_m[i]   = vld_q[i] && (tag_q[i] == rec_tag);
    end

    assign probe_hit = |probe_m;
    assign rec_dup   = |rec_m;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (rec_en && !rec_dup && !drop_all) begin
            ptr_q <= (ptr_q == PTR_W'(TRACK_N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < TRACK_N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n || drop_all) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end else if (rec_en && !rec_dup && ptr_q == PTR_W'(i)) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= rec_tag;
            end else if (drop_en && vld_q[i] && tag_q[i] == drop_tag) begin
                vld_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smc_pend_buf.sv
// Ordered queue of distinct pending hit lines with a sticky overflow mark.
module smc_pend_buf #(
    parameter int TAG_W = 27,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop_en,
    input  logic             clr_all,
    output logic [TAG_W-1:0] head_tag,
    output logic             any_pend,
    output logic             ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [TAG_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] same;
    logic             is_dup, do_wr, do_rd;

    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [PTR_W-1:0] rel;
        assign rel     = PTR_W'(i) - rd_q;
        assign live[i] = {1'b0, rel} < cnt_q;
        assign same[i] = live[i] && (slot_q[i] == push_tag);
    end

    assign is_dup   = |same;
    assign do_wr    = push_en && !is_dup && !ovf_q && (cnt_q != CNT_W'(DEPTH));
    assign do_rd    = pop_en && (cnt_q != '0);
    assign head_tag = slot_q[rd_q];
    assign any_pend = (cnt_q != '0);
    assign ovf      = ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (push_en && !is_dup && !ovf_q && cnt_q == CNT_W'(DEPTH)) begin
                ovf_q <= 1'b1;
            end
            if (do_wr) begin
                wr_q <= wr_q + 1'b1;
            end
            if (do_rd) begin
                rd_q <= rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (do_wr && wr_q == PTR_W'(i)) begin
                slot_q[i] <= push_tag;
            end
        end
    end
endmodule

// File: rtl/smc_ctrl_fsm.sv
// Drain sequencer: IDLE -start-> DRAIN -drained-> DONE -resume-> IDLE.
module smc_ctrl_fsm
    import smc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_retire,
    input  logic mode_switch,
    input  logic any_pend,
    input  logic ovf,
    output logic inv_req,
    output logic flush_req,
    output logic refetch,
    output logic stall
);
    smc_state_e state_q, state_d;
    logic       sw_q, sw_d;

    always_comb begin
        state_d = state_q;
        sw_d    = sw_q;
        unique case (state_q)
            ST_IDLE: begin
                if ((br_retire || mode_switch) && (any_pend || ovf)) begin
                    state_d = ST_DRAIN;
                    sw_d    = mode_switch;
                end
            end
            ST_DRAIN: begin
                if (mode_switch) begin
                    sw_d = 1'b1;
                end
                if (!any_pend && !ovf) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                sw_d    = 1'b0;
            end
            default: begin
                state_d = ST_IDLE;
                sw_d    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sw_q    <= sw_d;
        end
    end

    always_comb begin
        inv_req   = 1'b0;
        flush_req = 1'b0;
        refetch   = 1'b0;
        stall     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRAIN: begin
                inv_req   = any_pend && !ovf;
                flush_req = ovf;
                stall     = sw_q;
            end
            ST_DONE: begin
                refetch = 1'b1;
                stall   = sw_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/smc_detector.sv
module smc_detector #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PEND_N     = 4,
    parameter int TRACK_N    = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_legacy,
    input  logic              xlat_data_en,
    input  logic              xlat_inst_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic              br_retire,
    input  logic              mode_switch,
    input  logic              inv_ack,
    input  logic              flush_ack,
    output logic              inv_req,
    output logic [TAG_W-1:0]  inv_line,
    output logic              flush_req,
    output logic              refetch,
    output logic              stall
);
    logic [TAG_W-1:0] st_tag, fl_tag;
    logic             st_qual, trk_hit, any_pend, ovf;
    logic             pop_en, clr_all;
    logic             unused_off;

    assign st_tag     = st_addr[ADDR_W-1:OFF_W];
    assign fl_tag     = fl_addr[ADDR_W-1:OFF_W];
    assign unused_off = ^{st_addr[OFF_W-1:0], fl_addr[OFF_W-1:0]};
    assign st_qual    = st_valid && mode_legacy && xlat_data_en && xlat_inst_en;
    assign pop_en     = inv_req && inv_ack;
    assign clr_all    = flush_req && flush_ack;

    smc_line_tracker #(.TAG_W(TAG_W), .TRACK_N(TRACK_N)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_en    (fl_valid),
        .rec_tag   (fl_tag),
        .probe_tag (st_tag),
        .drop_en   (pop_en),
        .drop_tag  (inv_line),
        .drop_all  (clr_all),
        .probe_hit (trk_hit)
    );

    smc_pend_buf #(.TAG_W(TAG_W), .DEPTH(PEND_N)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (st_qual && trk_hit),
        .push_tag (st_tag),
        .pop_en   (pop_en),
        .clr_all  (clr_all),
        .head_tag (inv_line),
        .any_pend (any_pend),
        .ovf      (ovf)
    );

    smc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_retire   (br_retire),
        .mode_switch (mode_switch),
        .any_pend    (any_pend),
        .ovf         (ovf),
        .inv_req     (inv_req),
        .flush_req   (flush_req),
        .refetch     (refetch),
        .stall       (stall)
    );
endmodule

// File: rtl/smc_detector_chk.sv
module smc_detector_chk #(
    parameter int TAG_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_req,
    input logic [TAG_W-1:0] inv_line,
    input logic             inv_ack,
    input logic             flush_req,
    input logic             flush_ack,
    input logic             refetch,
    input logic             stall
);
    // R8
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_req && flush_req));

    // R7
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && !inv_ack |=> inv_req || flush_req);

    // R7
    inv_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && !inv_ack |=> flush_req || $stable(inv_line));

    // R8
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req);

    // R9
    refetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |=> !refetch);

    // R9
    refetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> !inv_req && !flush_req);

    // R10
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall && refetch |=> !stall);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !inv_req && !flush_req && !refetch && !stall);
endmodule

bind smc_detector smc_detector_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_req   (inv_req),
    .inv_line  (inv_line),
    .inv_ack   (inv_ack),
    .flush_req (flush_req),
    .flush_ack (flush_ack),
    .refetch   (refetch),
    .stall     (stall)
);

// File: tb/sim_smc_detector.sv
`timescale 1ns/1ps
module sim_smc_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_legacy = 1'b1, xlat_data_en = 1'b1, xlat_inst_en = 1'b1;
    logic        st_valid = 1'b0, fl_valid = 1'b0;
    logic [31:0] st_addr = '0, fl_addr = '0;
    logic        br_retire = 1'b0, mode_switch = 1'b0, inv_ack = 1'b0, flush_ack = 1'b0;
    logic        inv_req, flush_req, refetch, stall;
    logic [26:0] inv_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    smc_detector u0 (
        .clk(clk), .rst_n(rst_n), .mode_legacy(mode_legacy),
        .xlat_data_en(xlat_data_en), .xlat_inst_en(xlat_inst_en),
        .st_valid(st_valid), .st_addr(st_addr), .fl_valid(fl_valid), .fl_addr(fl_addr),
        .br_retire(br_retire), .mode_switch(mode_switch), .inv_ack(inv_ack),
        .flush_ack(flush_ack), .inv_req(inv_req), .inv_line(inv_line),
        .flush_req(flush_req), .refetch(refetch), .stall(stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode_legacy = 1'b1; xlat_data_en = 1'b1; xlat_inst_en = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic fetch(input logic [26:0] tag);
        fl_valid = 1'b1; fl_addr = {tag, 5'd0};
        step();
        fl_valid = 1'b0;
    endtask

    task automatic store(input logic [26:0] tag, input logic [4:0] off);
        st_valid = 1'b1; st_addr = {tag, off};
        step();
        st_valid = 1'b0;
    endtask

    task automatic branch();
        br_retire = 1'b1;
        step();
        br_retire = 1'b0;
    endtask

    task automatic ack_inv();
        inv_ack = 1'b1;
        step();
        inv_ack = 1'b0;
    endtask

    // After the last acknowledgement: one quiet cycle, one refetch cycle, then idle.
    task automatic finish_drain(input string req);
        chk(req, {inv_req, flush_req, refetch}, 3'b000);
        step();
        chk(req, refetch, 1'b1);
        step();
        chk(req, refetch, 1'b0);
    endtask

    function automatic logic [26:0] tag_of(input int i);
        return 27'h0100 + 27'(i * 3);
    endfunction

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        step();
        chk("R1", {inv_req, flush_req, refetch, stall}, 4'b0000);
        do_reset();
        chk("R1", {inv_req, flush_req, refetch, stall}, 4'b0000);

        // R2 R3 R7 R9 R11: single hit and its drain
        fetch(tag_of(0));
        store(tag_of(0), 5'd7);
        chk("R3", inv_req, 1'b0);
        step();
        chk("R3", inv_req, 1'b0);
        branch();
        chk("R2", inv_req, 1'b1);
        chk("R2", inv_line, 32'(tag_of(0)));
        step();
        chk("R7", {inv_req, 5'd0, inv_line}, {1'b1, 5'd0, tag_of(0)});
        ack_inv();
        finish_drain("R9");
        store(tag_of(0), 5'd0);
        branch();
        chk("R11", {inv_req, flush_req}, 2'b00);

        // R4 R5: sweep of mode and both translation enables
        for (int c = 0; c < 8; c++) begin
            do_reset();
            fetch(tag_of(1));
            mode_legacy = c[2]; xlat_data_en = c[1]; xlat_inst_en = c[0];
            store(tag_of(1), 5'(c));
            mode_legacy = 1'b1; xlat_data_en = 1'b1; xlat_inst_en = 1'b1;
            branch();
            if (c == 7) begin
                chk("R4 R5 qualified", inv_req, 1'b1);
                ack_inv();
                finish_drain("R9");
            end else if (c[2] == 1'b0) begin
                chk("R4", {inv_req, flush_req}, 2'b00);
            end else begin
                chk("R5", {inv_req, flush_req}, 2'b00);
            end
        end

        // R6: byte offset inside a line hits, neighbouring line does not
        do_reset();
        fetch(tag_of(2));
        store(tag_of(2) + 27'd1, 5'd0);
        branch();
        chk("R6 neighbour", inv_req, 1'b0);
        store(tag_of(2), 5'd31);
        branch();
        chk("R6 offset", {inv_req, 5'd0, inv_line}, {1'b1, 5'd0, tag_of(2)});
        ack_inv();
        finish_drain("R9");

        // R7 R8: sweep of distinct hit counts, with a repeated store
        for (int n = 1; n <= 5; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) fetch(tag_of(10 + i));
            for (int i = 0; i < n; i++) begin
                store(tag_of(10 + i), 5'(i));
                if (i == 0) store(tag_of(10), 5'd9);
            end
            branch();
            if (n <= 4) begin
                for (int i = 0; i < n; i++) begin
                    chk("R7 order", {inv_req, 5'd0, inv_line}, {1'b1, 5'd0, tag_of(10 + i)});
                    ack_inv();
                end
                finish_drain("R7 count");
            end else begin
                chk("R8 flush", {flush_req, inv_req}, 2'b10);
                step();
                chk("R8 hold", flush_req, 1'b1);
                flush_ack = 1'b1;
                step();
                flush_ack = 1'b0;
                finish_drain("R8");
                store(tag_of(10), 5'd0);
                branch();
                chk("R8 cleared", {inv_req, flush_req}, 2'b00);
            end
        end

        // R12: ninth distinct fetch evicts the first
        do_reset();
        for (int i = 0; i < 9; i++) fetch(tag_of(20 + i));
        store(tag_of(20), 5'd0);
        branch();
        chk("R12 evicted", inv_req, 1'b0);
        store(tag_of(28), 5'd0);
        branch();
        chk("R12 newest", {inv_req, 5'd0, inv_line}, {1'b1, 5'd0, tag_of(28)});
        ack_inv();
        finish_drain("R9");

        // R10: mode switch with and without pending hits
        do_reset();
        mode_switch = 1'b1;
        step();
        mode_switch = 1'b0;
        chk("R10 empty", stall, 1'b0);
        fetch(tag_of(30));
        store(tag_of(30), 5'd4);
        mode_switch = 1'b1;
        mode_legacy = 1'b0;
        step();
        mode_switch = 1'b0;
        chk("R10 stall", {stall, inv_req}, 2'b11);
        ack_inv();
        chk("R10 stall held", stall, 1'b1);
        step();
        chk("R10 refetch", {stall, refetch}, 2'b11);
        step();
        chk("R10 released", stall, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule